// File: doc/BRIEF.md
# Handshake Bus Slave Port

This block is the responding end of a two-wire ready/acknowledge bus. A master places a 16-bit address and, when it writes, a 32-bit data word on the bus. It then raises ready and waits for acknowledge. The master drops ready after acknowledge rises, and the transfer ends when acknowledge falls. The slave answers only transfers whose address equals the channel address it was given at start. Any other address leaves it silent.

A local controller starts one message at a time. It gives the direction (send puts words from the local word buffer onto the bus, receive stores bus words into that buffer), the channel address and a word count. The slave then serves that many handshakes, filling or draining the buffer from entry 0 upward, and pulses done once the last acknowledge has been lowered. The controller fills the buffer before a send and reads it back after a receive, through a host write port and a host read port. The ready input comes from the master's clock domain and passes through a two-stage synchronizer.

Top module: `hsk_slave_port`

## Requirements
- R1: After a synchronous active-low reset, `bus_ack_o`, `bus_data_oe_o` and `done_o` are 0 and `bus_data_o` is all zeros.
- R2: A start with `word_cnt_i` = 0 raises `done_o` for exactly one cycle, at the clock edge that takes the start. No acknowledge is raised.
- R3: While a message is active, a raised ready with a bus address different from the channel address latched at start leaves `bus_ack_o` low for as long as ready stays high.
- R4: Counting clock edges from the first one that sees ready high with a matching address, `bus_ack_o` rises at the fifth edge. That is two synchronizer stages, then a sample, a drive and a raise state.
- R5: `bus_ack_o` stays high while ready stays high. It falls at the fourth clock edge after ready goes low.
- R6: In send mode (`dir_send_i` = 1), transfer k of the message (k = 0, 1, ...) presents buffer entry k on `bus_data_o` while acknowledge is high.
- R7: In receive mode (`dir_send_i` = 0), the bus data of transfer k is written into buffer entry k. After done, it reads back on `buf_rdata_o`.
- R8: `bus_data_oe_o` is 1 only in send mode. It rises at the edge after the address match and falls together with acknowledge. At all other times it is 0, and `bus_data_o` is zero whenever it is 0.
- R9: `done_o` is a one-cycle pulse. It rises at the same edge at which the acknowledge of the last word falls, and it stays low at the acknowledge fall of every earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a message (taken only while idle) |
| dir_send_i | input | 1 | 1 = send buffer words to the bus, 0 = receive words into the buffer |
| chan_addr_i | input | 16 | Channel address this message answers to |
| word_cnt_i | input | 4 | Number of words in the message (0 to 8) |
| bus_rdy_i | input | 1 | Master ready, asynchronous to clk |
| bus_addr_i | input | 16 | Bus address from the master |
| bus_data_i | input | 32 | Bus data from the master |
| bus_data_o | output | 32 | Data the slave drives in send mode |
| bus_data_oe_o | output | 1 | Enable for bus_data_o onto the shared data lines |
| bus_ack_o | output | 1 | Slave acknowledge |
| done_o | output | 1 | One-cycle pulse when the message is complete |
| buf_we_i | input | 1 | Host write strobe into the word buffer (taken while idle) |
| buf_waddr_i | input | 3 | Host write entry |
| buf_wdata_i | input | 32 | Host write word |
| buf_raddr_i | input | 3 | Host read entry |
| buf_rdata_o | output | 32 | Host read word |

## Verification
A state register stuck or skipped in the handshake sequence shows at once as an acknowledge that comes one edge early or late, or never. The latency checks of five edges to rise and four to fall catch this on the first word. A wrong word pointer or remaining count puts the wrong data word on the bus, stores it in the wrong buffer entry, or moves the done pulse by a whole word. The sweep over every word count in both directions exposes that within one message. A wrong address compare shows as an acknowledge to a foreign address within five edges, or as a matching transfer that is never answered.

// File: rtl/hsk_pkg.sv
// Shared types for the handshake bus slave port.
package hsk_pkg;

    // Controller states: idle, then one pass of the five-step handshake per word.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_DRIVE  = 3'd2,
        ST_RAISE  = 3'd3,
        ST_HOLD   = 3'd4,
        ST_DROP   = 3'd5
    } hsk_state_e;

endpackage

// File: rtl/hsk_sync2.sv
// Two-flop synchronizer for a single-bit level from another clock domain.
// Assumes the input is a slow level (held for several clk periods).
module hsk_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_o    <= 1'b0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/hsk_word_buf.sv
// Local word buffer: one synchronous write port, two combinational read ports
// (one for the handshake controller, one for the host). Contents are not reset.
module hsk_word_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [PTR_W-1:0]  raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/hsk_slave_fsm.sv
// Handshake controller: latches direction, channel address and word count at
// start, then for each word samples ready+address, drives or latches data,
// raises acknowledge, waits for ready low, lowers acknowledge.
// Assumes rdy_s_i is already synchronized and the master keeps address and
// data stable while ready is high.
module hsk_slave_fsm
    import hsk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_send_i,
    input  logic [ADDR_W-1:0] chan_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic              rdy_s_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [PTR_W-1:0]  mem_ptr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              oe_o,
    output logic              ack_o,
    output logic              done_o,
    output hsk_state_e        state_o,
    output logic              dir_o,
    output logic [ADDR_W-1:0] chan_o
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    hsk_state_e        state_q;
    logic              dir_q;
    logic [ADDR_W-1:0] chan_q;
    logic [CNT_W-1:0]  left_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              ack_q, oe_q, done_q;
    logic [DATA_W-1:0] dout_q;

    // State sequencing plus the registered bus outputs and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            chan_q  <= '0;
            left_q  <= '0;
            ptr_q   <= '0;
            ack_q   <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            dout_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dir_q  <= dir_send_i;
                        chan_q <= chan_addr_i;
                        left_q <= word_cnt_i;
                        ptr_q  <= '0;
                        if (word_cnt_i == '0) done_q  <= 1'b1;
                        else                  state_q <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    if (rdy_s_i && (bus_addr_i == chan_q)) state_q <= ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (dir_q) begin
                        dout_q <= mem_rdata_i;
                        oe_q   <= 1'b1;
                    end
                    ptr_q   <= ptr_q + PTR_ONE;
                    state_q <= ST_RAISE;
                end
                ST_RAISE: begin
                    ack_q   <= 1'b1;
                    left_q  <= left_q - CNT_ONE;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!rdy_s_i) state_q <= ST_DROP;
                end
                ST_DROP: begin
                    ack_q <= 1'b0;
                    oe_q  <= 1'b0;
                    if (left_q != '0) begin
                        state_q <= ST_SAMPLE;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Receive path writes the bus word at the drive step.
    assign mem_we_o    = (state_q == ST_DRIVE) && !dir_q;
    assign mem_wdata_o = bus_data_i;
    assign mem_ptr_o   = ptr_q;
    assign dout_o      = dout_q;
    assign oe_o        = oe_q;
    assign ack_o       = ack_q;
    assign done_o      = done_q;
    assign state_o     = state_q;
    assign dir_o       = dir_q;
    assign chan_o      = chan_q;
endmodule

// File: rtl/hsk_slave_port.sv
// Top of the handshake bus slave port: synchronizer, word buffer and
// controller. Host buffer writes are honoured only while the controller idles.
// Assumes DEPTH is a power of two.
module hsk_slave_port
    import hsk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_send_i,
    input  logic [ADDR_W-1:0] chan_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic              bus_rdy_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe_o,
    output logic              bus_ack_o,
    output logic              done_o,
    input  logic              buf_we_i,
    input  logic [PTR_W-1:0]  buf_waddr_i,
    input  logic [DATA_W-1:0] buf_wdata_i,
    input  logic [PTR_W-1:0]  buf_raddr_i,
    output logic [DATA_W-1:0] buf_rdata_o
);
    logic              rdy_s;
    logic [PTR_W-1:0]  mem_ptr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, dout;
    logic              oe;
    hsk_state_e        state;
    logic              dir_q;
    logic [ADDR_W-1:0] chan_q;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;

    hsk_sync2 u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_rdy_i),
        .q_o   (rdy_s)
    );

    hsk_slave_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PTR_W  (PTR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_send_i  (dir_send_i),
        .chan_addr_i (chan_addr_i),
        .word_cnt_i  (word_cnt_i),
        .rdy_s_i     (rdy_s),
        .bus_addr_i  (bus_addr_i),
        .bus_data_i  (bus_data_i),
        .mem_rdata_i (mem_rdata),
        .mem_ptr_o   (mem_ptr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .dout_o      (dout),
        .oe_o        (oe),
        .ack_o       (bus_ack_o),
        .done_o      (done_o),
        .state_o     (state),
        .dir_o       (dir_q),
        .chan_o      (chan_q)
    );

    // Controller owns the write port during a message; host only while idle.
    always_comb begin
        if (mem_we) begin
            wr_en   = 1'b1;
            wr_addr = mem_ptr;
            wr_data = mem_wdata;
        end else begin
            wr_en   = buf_we_i && (state == ST_IDLE);
            wr_addr = buf_waddr_i;
            wr_data = buf_wdata_i;
        end
    end

    hsk_word_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_buf (
        .clk       (clk),
        .we_i      (wr_en),
        .waddr_i   (wr_addr),
        .wdata_i   (wr_data),
        .raddr_a_i (mem_ptr),
        .rdata_a_o (mem_rdata),
        .raddr_b_i (buf_raddr_i),
        .rdata_b_o (buf_rdata_o)
    );

    assign bus_data_oe_o = oe;
    assign bus_data_o    = oe ? dout : '0;
endmodule

// File: rtl/hsk_slave_port_chk.sv
// Protocol checker for hsk_slave_port, attached by bind.
module hsk_slave_port_chk
    import hsk_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy_s,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] chan_q,
    input logic              dir_q,
    input hsk_state_e        state,
    input logic              ack,
    input logic              oe,
    input logic              done
);
    AST_ACK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(rdy_s && (bus_addr == chan_q), 3)); // R3
    AST_ACK_FALL_AFTER_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(!rdy_s, 2)); // R5
    AST_OE_SEND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> dir_q); // R8
    AST_OE_COVERS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && dir_q) |-> oe); // R8
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE)); // R9
    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !ack); // R1
endmodule

bind hsk_slave_port hsk_slave_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_s    (rdy_s),
    .bus_addr (bus_addr_i),
    .chan_q   (chan_q),
    .dir_q    (dir_q),
    .state    (state),
    .ack      (bus_ack_o),
    .oe       (bus_data_oe_o),
    .done     (done_o)
);

// File: tb/hsk_slave_port_bench.sv
// Sweep of both directions and every word count 0..DEPTH, acting as master.
module hsk_slave_port_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] CHAN = 16'h3C5A;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, start, dir_send, rdy, oe, ack, done, bwe;
    logic [ADDR_W-1:0] chan, baddr;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] bdin, bdout, bwdata, brdata;
    logic [PTR_W-1:0]  bwaddr, braddr;

    hsk_slave_port u_hsk_slave_port (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dir_send_i(dir_send),
        .chan_addr_i(chan), .word_cnt_i(cnt), .bus_rdy_i(rdy),
        .bus_addr_i(baddr), .bus_data_i(bdin), .bus_data_o(bdout),
        .bus_data_oe_o(oe), .bus_ack_o(ack), .done_o(done),
        .buf_we_i(bwe), .buf_waddr_i(bwaddr), .buf_wdata_i(bwdata),
        .buf_raddr_i(braddr), .buf_rdata_o(brdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int dir, int n, int k);
        return 32'h5A00_0000 ^ (n << 16) ^ (dir << 12) ^ (k * 32'h0001_0203);
    endfunction

    // Watchdog: a hung run counts as a miscompare and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Foreign-address handshake: must never be acknowledged (R3).
    task automatic foreign(logic [ADDR_W-1:0] a);
        bit seen = 1'b0;
        @(negedge clk);
        baddr = a; rdy = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        chk("R3", "ack to foreign address", 32'(seen), 32'd0);
        rdy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One master word transfer with latency, data and done checks.
    task automatic word(bit send, logic [31:0] wdat, logic [31:0] exp_out, bit last);
        int k;
        @(negedge clk);
        baddr = CHAN; bdin = wdat; rdy = 1'b1;
        k = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            k = i;
            if (ack) break;
        end
        chk("R4", "ack rise latency", 32'(k), 32'd5);
        if (send) begin
            chk("R6", "sent word", bdout, exp_out);
            chk("R8", "oe in send", 32'(oe), 32'd1);
        end else begin
            chk("R8", "oe in receive", 32'(oe), 32'd0);
            chk("R8", "data zero when not driven", bdout, 32'd0);
        end
        repeat (3) @(negedge clk);
        chk("R5", "ack held while ready high", 32'(ack), 32'd1);
        rdy = 1'b0;
        k = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            k = i;
            if (!ack) break;
        end
        chk("R5", "ack fall latency", 32'(k), 32'd4);
        chk("R9", "done at ack fall", 32'(done), 32'(last));
        chk("R8", "oe low after ack fall", 32'(oe), 32'd0);
        if (last) begin
            @(negedge clk);
            chk("R9", "done one cycle", 32'(done), 32'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; dir_send = 1'b0; rdy = 1'b0;
        chan = '0; cnt = '0; baddr = '0; bdin = '0;
        bwe = 1'b0; bwaddr = '0; bwdata = '0; braddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ack after reset", 32'(ack), 32'd0);
        chk("R1", "oe after reset", 32'(oe), 32'd0);
        chk("R1", "done after reset", 32'(done), 32'd0);
        chk("R1", "data after reset", bdout, 32'd0);

        for (int dir = 1; dir >= 0; dir--) begin
            for (int n = 0; n <= DEPTH; n++) begin
                // Preload: send gets the pattern, receive gets a poison value.
                for (int k = 0; k < DEPTH; k++) begin
                    @(negedge clk);
                    bwe = 1'b1; bwaddr = PTR_W'(k);
                    bwdata = (dir == 1) ? pat(dir, n, k) : ~pat(dir, n, k);
                end
                @(negedge clk);
                bwe = 1'b0;
                start = 1'b1; dir_send = dir[0]; chan = CHAN; cnt = CNT_W'(n);
                @(negedge clk);
                start = 1'b0;
                if (n == 0) begin
                    chk("R2", "done on zero count", 32'(done), 32'd1);
                    @(negedge clk);
                    chk("R2", "done pulse width", 32'(done), 32'd0);
                    chk("R2", "no ack on zero count", 32'(ack), 32'd0);
                end else begin
                    for (int k = 0; k < n; k++) begin
                        if (k == 1) foreign(CHAN ^ 16'h0001);
                        if (k == 2) foreign(CHAN ^ 16'h8000);
                        word(dir[0], pat(dir, n, k) ^ 32'h00FF_0000,
                             pat(dir, n, k), (k == n - 1));
                    end
                    if (dir == 0) begin
                        for (int k = 0; k < DEPTH; k++) begin
                            @(negedge clk);
                            braddr = PTR_W'(k);
                            #1;
                            chk("R7", "received buffer entry", brdata,
                                (k < n) ? (pat(dir, n, k) ^ 32'h00FF_0000)
                                        : ~pat(dir, n, k));
                        end
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule